// File: doc/BRIEF.md
# Runtime-Configurable Hard-Decision Viterbi Decoder

This block recovers the information bits of a convolutionally coded stream from hard-decision code bits. One datapath serves three constraint lengths (3, 5 and 7) and two code rates (one half and one third). A configuration input selects the mode. The decoder samples that input at the first symbol of each block, so the mode can change between blocks without any other handshake.

Decoding runs on fixed blocks of 5·K trellis steps. For each accepted symbol, an array of butterfly cores performs add-compare-select on the path metrics. The survivor decisions go into a decision memory. After the last symbol of a block, a minimum search over the active states picks the starting state. A reconstructor then walks the decision memory backwards, and a last-in first-out store returns the recovered bits in their original order as a contiguous output burst. Metrics are reset at the start of every block, so the encoder is expected to start each block from the all-zero state.

Top module: `vit_decoder`

## Requirements
- R1: `cfg_k` selects the constraint length: 2'b00 gives K=3, 2'b01 gives K=5, and 2'b10 or 2'b11 give K=7. A block is 5·K accepted symbols, and it produces exactly 5·K decoded bits on consecutive `out_valid` cycles.
- R2: With `cfg_rate`=0 (rate one half), only `in_sym[1:0]` is used, and `in_sym[2]` has no effect on the output. With `cfg_rate`=1 (rate one third), all three bits are used. `in_sym[i]` is the code bit of generator i.
- R3: The generators, in octal, are used in the order g0, g1, g2. For rate one half: K=3 uses 7,5; K=5 uses 23,35; K=7 uses 171,133. For rate one third: K=3 uses 7,7,5; K=5 uses 25,33,37; K=7 uses 133,145,175. The polynomial's highest bit taps the newest input bit and its lowest bit the oldest.
- R4: For an error-free block from an encoder that starts in the zero state, the output equals the encoder's input bits.
- R5: A single inverted code bit within the first half of a block is corrected.
- R6: Path metrics are 8-bit and are renormalised every step by the previous minimum. The smallest active metric never exceeds 3 and no active metric exceeds 127.
- R7: Traceback starts from the lowest-index active state holding the smallest path metric.
- R8: Decoded bits leave in the order their steps were received.
- R9: `in_ready` is high only while a block is being accepted and is never high together with `out_valid`.
- R10: The configuration is taken at the first symbol of a block. Changes to `cfg_k` or `cfg_rate` later in the block have no effect on that block.
- R11: After reset, `in_ready`=1 and `out_valid`=0. State 0 has metric 0 and all other states hold a penalty metric.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_k | input | 2 | Constraint-length select |
| cfg_rate | input | 1 | 0: rate one half, 1: rate one third |
| in_valid | input | 1 | Symbol valid |
| in_ready | output | 1 | Decoder accepting symbols |
| in_sym | input | 3 | Hard code bits of one trellis step |
| out_valid | output | 1 | Decoded bit valid |
| out_bit | output | 1 | Decoded bit |

## Verification
Several properties are checked on every cycle: the bounds on the renormalised metrics, the exclusion between `in_ready` and `out_valid`, the configuration holding within a block, the length of every output burst, the reset state, and the traceback start lying inside the active states. Whether the polynomials, the minimum-state start, the LIFO ordering and error correction are right only shows when decoded blocks are compared against encoded random and directed data, with and without a flipped bit, for every mode.

// File: rtl/vit_pkg.sv
package vit_pkg;
    localparam int K_MAX   = 7;
    localparam int SW      = K_MAX - 1;
    localparam int NS_MAX  = 1 << SW;
    localparam int NBF_MAX = NS_MAX / 2;
    localparam int MW      = 8;
    localparam int L_MAX   = 5 * K_MAX;
    localparam int LW      = $clog2(L_MAX + 1);

    typedef logic [MW-1:0] metric_t;
    localparam metric_t INIT_PEN = metric_t'(32);

    typedef logic [K_MAX-1:0] poly_t;

    typedef struct packed {
        logic [1:0] klen_sel;
        logic       rate3;
    } cfg_t;

    typedef struct packed {
        poly_t g2;
        poly_t g1;
        poly_t g0;
    } polyset_t;

    typedef enum logic [1:0] {ST_ACC, ST_FIND, ST_BACK} phase_e;
    typedef enum logic [1:0] {TB_IDLE, TB_WALK, TB_POP} tbmode_e;

    function automatic logic [2:0] klen(cfg_t c);
        case (c.klen_sel)
            2'd0:    return 3'd3;
            2'd1:    return 3'd5;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [SW:0] nstates(cfg_t c);
        case (c.klen_sel)
            2'd0:    return (SW+1)'(4);
            2'd1:    return (SW+1)'(16);
            default: return (SW+1)'(64);
        endcase
    endfunction

    function automatic logic [LW-1:0] nsteps(cfg_t c);
        case (c.klen_sel)
            2'd0:    return LW'(15);
            2'd1:    return LW'(25);
            default: return LW'(35);
        endcase
    endfunction

    function automatic polyset_t polys(cfg_t c);
        polyset_t p;
        case ({c.klen_sel, c.rate3})
            3'b000:  p = '{g2: 7'o0,   g1: 7'o5,   g0: 7'o7};
            3'b001:  p = '{g2: 7'o5,   g1: 7'o7,   g0: 7'o7};
            3'b010:  p = '{g2: 7'o0,   g1: 7'o35,  g0: 7'o23};
            3'b011:  p = '{g2: 7'o37,  g1: 7'o33,  g0: 7'o25};
            3'b100, 3'b110: p = '{g2: 7'o0,   g1: 7'o133, g0: 7'o171};
            default: p = '{g2: 7'o175, g1: 7'o145, g0: 7'o133};
        endcase
        return p;
    endfunction

    // Hamming distance between received bits and a branch's expected code bits
    function automatic logic [1:0] bmetric(polyset_t p, logic r3,
                                           logic [K_MAX-1:0] rg, logic [2:0] rx);
        logic e0, e1, e2;
        e0 = ^(rg & p.g0);
        e1 = ^(rg & p.g1);
        e2 = ^(rg & p.g2);
        return {1'b0, rx[0] ^ e0} + {1'b0, rx[1] ^ e1} +
               (r3 ? {1'b0, rx[2] ^ e2} : 2'd0);
    endfunction
endpackage

// File: rtl/vit_acs_bfly.sv
module vit_acs_bfly
    import vit_pkg::*;
(
    input  logic    en,
    input  metric_t pm_even,
    input  metric_t pm_odd,
    input  metric_t sub,
    input  logic [1:0] bm_e0,
    input  logic [1:0] bm_o0,
    input  logic [1:0] bm_e1,
    input  logic [1:0] bm_o1,
    output metric_t nm_lo,
    output metric_t nm_hi,
    output logic    d_lo,
    output logic    d_hi
);
    logic [MW:0] se0, so0, se1, so1, w0, w1, r0, r1;
    logic        c0, c1;

    always_comb begin
        se0 = {1'b0, pm_even} + {{(MW-1){1'b0}}, bm_e0};
        so0 = {1'b0, pm_odd}  + {{(MW-1){1'b0}}, bm_o0};
        se1 = {1'b0, pm_even} + {{(MW-1){1'b0}}, bm_e1};
        so1 = {1'b0, pm_odd}  + {{(MW-1){1'b0}}, bm_o1};
        c0  = so0 < se0;
        c1  = so1 < se1;
        w0  = c0 ? so0 : se0;
        w1  = c1 ? so1 : se1;
        r0  = w0 - {1'b0, sub};
        r1  = w1 - {1'b0, sub};
        nm_lo = (!en || r0[MW]) ? '1 : r0[MW-1:0];
        nm_hi = (!en || r1[MW]) ? '1 : r1[MW-1:0];
        d_lo  = en & c0;
        d_hi  = en & c1;
    end
endmodule

// File: rtl/vit_acs_array.sv
module vit_acs_array
    import vit_pkg::*;
(
    input  cfg_t    cfg,
    input  logic [2:0] rx,
    input  metric_t sub,
    input  metric_t pm [NS_MAX],
    output metric_t nm [NS_MAX],
    output logic [NS_MAX-1:0] dec
);
    localparam int NBW = $clog2(NBF_MAX);

    logic [2:0]       kw;
    logic [SW-1:0]    half;
    polyset_t         ps;
    logic [K_MAX-1:0] ubit;
    metric_t          lo [NBF_MAX];
    metric_t          hi [NBF_MAX];
    logic [NBF_MAX-1:0] dlo, dhi;

    always_comb begin
        kw   = klen(cfg);
        half = SW'(nstates(cfg) >> 1);
        ps   = polys(cfg);
        ubit = K_MAX'(1) << (kw - 3'd1);
    end

    for (genvar j = 0; j < NBF_MAX; j++) begin : g_core
        localparam logic [K_MAX-1:0] RE = K_MAX'(2*j);
        localparam logic [K_MAX-1:0] RO = K_MAX'(2*j + 1);
        logic [1:0] b_e0, b_o0, b_e1, b_o1;
        logic       en_c;
        assign en_c = SW'(j) < half;
        assign b_e0 = bmetric(ps, cfg.rate3, RE, rx);
        assign b_o0 = bmetric(ps, cfg.rate3, RO, rx);
        assign b_e1 = bmetric(ps, cfg.rate3, RE | ubit, rx);
        assign b_o1 = bmetric(ps, cfg.rate3, RO | ubit, rx);
        vit_acs_bfly u_bf (
            .en     (en_c),
            .pm_even(pm[2*j]),
            .pm_odd (pm[2*j+1]),
            .sub    (sub),
            .bm_e0  (b_e0),
            .bm_o0  (b_o0),
            .bm_e1  (b_e1),
            .bm_o1  (b_o1),
            .nm_lo  (lo[j]),
            .nm_hi  (hi[j]),
            .d_lo   (dlo[j]),
            .d_hi   (dhi[j])
        );
    end

    // Successor of core j is j (input 0) or j+half (input 1); half follows K
    always_comb begin
        for (int n = 0; n < NS_MAX; n++) begin
            int idx;
            idx = n - int'(half);
            if (n < int'(half)) begin
                nm[n]  = lo[NBW'(n)];
                dec[n] = dlo[NBW'(n)];
            end else if (n < 2 * int'(half)) begin
                nm[n]  = hi[NBW'(idx)];
                dec[n] = dhi[NBW'(idx)];
            end else begin
                nm[n]  = '1;
                dec[n] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/vit_min_find.sv
module vit_min_find
    import vit_pkg::*;
(
    input  metric_t       pm [NS_MAX],
    input  logic [SW:0]   ns_act,
    output metric_t       min_val,
    output logic [SW-1:0] min_idx
);
    always_comb begin
        min_val = pm[0];
        min_idx = '0;
        for (int n = 1; n < NS_MAX; n++) begin
            if (n < int'(ns_act) && pm[n] < min_val) begin
                min_val = pm[n];
                min_idx = SW'(n);
            end
        end
    end
endmodule

// File: rtl/vit_traceback.sv
module vit_traceback
    import vit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LW-1:0]     wr_addr,
    input  logic [NS_MAX-1:0] wr_dec,
    input  logic              start,
    input  logic [SW-1:0]     start_state,
    input  logic [2:0]        kw,
    input  logic [LW-1:0]     nstep,
    output logic              out_valid,
    output logic              out_bit,
    output logic              done
);
    logic [NS_MAX-1:0] dmem [L_MAX];
    logic [L_MAX-1:0]  lifo;
    logic [LW-1:0]     t, sp;
    logic [SW-1:0]     st, smask, pred;
    logic              bit_now;
    tbmode_e           mode;

    always_comb begin
        smask   = SW'((K_MAX'(1) << (kw - 3'd1)) - K_MAX'(1));
        bit_now = st[3'(kw - 3'd2)];
        pred    = ((st << 1) & smask) | SW'(dmem[t][st]);
        out_valid = (mode == TB_POP);
        out_bit   = (mode == TB_POP) ? lifo[sp - LW'(1)] : 1'b0;
        done      = (mode == TB_POP) && (sp == LW'(1));
    end

    always_ff @(posedge clk) begin
        if (wr_en) dmem[wr_addr] <= wr_dec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= TB_IDLE;
            t    <= '0;
            sp   <= '0;
            st   <= '0;
            lifo <= '0;
        end else begin
            case (mode)
                TB_IDLE: if (start) begin
                    mode <= TB_WALK;
                    st   <= start_state;
                    t    <= nstep - LW'(1);
                    sp   <= '0;
                end
                TB_WALK: begin
                    lifo[sp] <= bit_now;
                    sp       <= sp + LW'(1);
                    st       <= pred;
                    if (t == '0) mode <= TB_POP;
                    else         t    <= t - LW'(1);
                end
                TB_POP: begin
                    sp <= sp - LW'(1);
                    if (sp == LW'(1)) mode <= TB_IDLE;
                end
                default: mode <= TB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vit_decoder.sv
module vit_decoder
    import vit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_k,
    input  logic       cfg_rate,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [2:0] in_sym,
    output logic       out_valid,
    output logic       out_bit
);
    phase_e            phase;
    logic [LW-1:0]     cnt;
    cfg_t              cfg_q, cfg_eff;
    metric_t           pm [NS_MAX];
    metric_t           nm [NS_MAX];
    logic [NS_MAX-1:0] dec;
    metric_t           min_val;
    logic [SW-1:0]     min_idx;
    logic [SW:0]       ns_act;
    logic [LW-1:0]     nstep;
    logic              accept, tb_done;

    always_comb begin
        cfg_eff  = (cnt == '0) ? cfg_t'{klen_sel: cfg_k, rate3: cfg_rate} : cfg_q;
        ns_act   = nstates(cfg_eff);
        nstep    = nsteps(cfg_eff);
        in_ready = (phase == ST_ACC);
        accept   = in_ready && in_valid;
    end

    vit_min_find u_min (
        .pm(pm), .ns_act(ns_act), .min_val(min_val), .min_idx(min_idx)
    );

    vit_acs_array u_acs (
        .cfg(cfg_eff), .rx(in_sym), .sub(min_val), .pm(pm), .nm(nm), .dec(dec)
    );

    vit_traceback u_tb (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (accept),
        .wr_addr    (cnt),
        .wr_dec     (dec),
        .start      (phase == ST_FIND),
        .start_state(min_idx),
        .kw         (klen(cfg_eff)),
        .nstep      (nstep),
        .out_valid  (out_valid),
        .out_bit    (out_bit),
        .done       (tb_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_ACC;
            cnt   <= '0;
            cfg_q <= '0;
            for (int n = 0; n < NS_MAX; n++) pm[n] <= (n == 0) ? '0 : INIT_PEN;
        end else begin
            case (phase)
                ST_ACC: if (accept) begin
                    for (int n = 0; n < NS_MAX; n++) pm[n] <= nm[n];
                    if (cnt == '0) cfg_q <= cfg_eff;
                    if (cnt == nstep - LW'(1)) phase <= ST_FIND;
                    else                       cnt   <= cnt + LW'(1);
                end
                ST_FIND: phase <= ST_BACK;
                ST_BACK: if (tb_done) begin
                    phase <= ST_ACC;
                    cnt   <= '0;
                    for (int n = 0; n < NS_MAX; n++) pm[n] <= (n == 0) ? '0 : INIT_PEN;
                end
                default: phase <= ST_ACC;
            endcase
        end
    end
endmodule

// File: rtl/vit_decoder_chk.sv
module vit_decoder_chk
    import vit_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_ready,
    input logic          out_valid,
    input phase_e        phase,
    input logic [LW-1:0] cnt,
    input cfg_t          cfg_q,
    input metric_t       min_val,
    input logic [SW-1:0] min_idx,
    input logic [SW:0]   ns_act,
    input metric_t       pm [NS_MAX]
);
    metric_t       max_act;
    logic [LW-1:0] run;

    always_comb begin
        max_act = '0;
        for (int n = 0; n < NS_MAX; n++)
            if (n < int'(ns_act) && pm[n] > max_act) max_act = pm[n];
    end

    always_ff @(posedge clk) begin
        if (rst)            run <= '0;
        else if (out_valid) run <= run + LW'(1);
        else                run <= '0;
    end

    AST_READY_OUT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid)); // R9
    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_BACK) |-> (min_val <= metric_t'(3))); // R6
    AST_MAX_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_BACK) |-> (max_act <= metric_t'(127))); // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && $past(cnt) != '0) |-> $stable(cfg_q)); // R10
    AST_RUN_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> (run == nsteps(cfg_q))); // R1
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid)); // R11
    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_FIND) |-> ((SW+1)'(min_idx) < ns_act)); // R7
endmodule

bind vit_decoder vit_decoder_chk u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .phase(phase), .cnt(cnt), .cfg_q(cfg_q), .min_val(min_val),
    .min_idx(min_idx), .ns_act(ns_act), .pm(pm)
);

// File: tb/vit_decoder_tb.sv
module vit_decoder_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cfg_k;
    logic       cfg_rate;
    logic       in_valid;
    logic       in_ready;
    logic [2:0] in_sym;
    logic       out_valid;
    logic       out_bit;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    vit_decoder u_dut (
        .clk(clk), .rst(rst), .cfg_k(cfg_k), .cfg_rate(cfg_rate),
        .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] got,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int klen_of(input logic [1:0] kc);
        return (kc == 2'd0) ? 3 : (kc == 2'd1) ? 5 : 7;
    endfunction

    // Generator table from R3, octal, highest bit taps newest input
    function automatic logic [6:0] gen(input int k, input bit r3, input int which);
        case (k)
            3: return r3 ? ((which == 2) ? 7'o5 : 7'o7)
                         : ((which == 0) ? 7'o7 : 7'o5);
            5: return r3 ? ((which == 0) ? 7'o25 : (which == 1) ? 7'o33 : 7'o37)
                         : ((which == 0) ? 7'o23 : 7'o35);
            default: return r3 ? ((which == 0) ? 7'o133 : (which == 1) ? 7'o145 : 7'o175)
                               : ((which == 0) ? 7'o171 : 7'o133);
        endcase
    endfunction

    // pattern: 0 random, 1 all zeros, 2 all ones
    task automatic run_block(input logic [1:0] kc, input bit r3, input int pattern,
                             input bit do_flip, input bit mid_change, input string tag);
        int k, len, got_n, nb;
        logic [34:0] u, got;
        logic [2:0]  sym [35];
        logic [6:0]  st, rg;
        bit          ready_low;
        k = klen_of(kc);
        len = 5 * k;
        nb = r3 ? 3 : 2;
        u = '0;
        st = '0;
        for (int i = 0; i < len; i++) begin
            u[i] = (pattern == 0) ? 1'($urandom) : (pattern == 2);
            rg = st | (7'(u[i]) << (k - 1));
            sym[i] = '0;
            for (int g = 0; g < nb; g++) sym[i][g] = ^(rg & gen(k, r3, g));
            if (!r3) sym[i][2] = 1'($urandom);
            st = rg >> 1;
        end
        if (do_flip) begin
            int fs, fb;
            fs = int'($urandom % 32'(len / 2));
            fb = int'($urandom % 32'(nb));
            sym[fs][fb] = ~sym[fs][fb];
        end
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        cfg_k = kc;
        cfg_rate = r3;
        for (int i = 0; i < len; i++) begin
            if (i > 0) @(negedge clk);
            in_valid = 1'b1;
            in_sym = sym[i];
            if (mid_change && i == 1) begin
                cfg_k = (kc == 2'd1) ? 2'd2 : 2'd1;
                cfg_rate = ~r3;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sym = 3'($urandom);
        got = '0;
        got_n = 0;
        ready_low = 1'b1;
        for (int c = 0; c < 400; c++) begin
            if (out_valid) begin
                if (got_n < 35) got[got_n] = out_bit;
                got_n++;
                if (in_ready) ready_low = 1'b0;
            end else if (got_n > 0) begin
                break;
            end
            @(negedge clk);
        end
        check(got == u, {tag, " bits"}, 64'(got), 64'(u));
        check(got_n == len && in_ready && !out_valid, "R1 output count",
              64'(got_n), 64'(len));
        check(ready_low, "R9 ready low during output", 64'(!ready_low), 64'd0);
        cfg_k = kc;
        cfg_rate = r3;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1;
        cfg_k = 2'd0;
        cfg_rate = 1'b0;
        in_valid = 1'b0;
        in_sym = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R11 in_ready after reset", 64'(in_ready), 64'd1);
        check(out_valid == 1'b0, "R11 out_valid after reset", 64'(out_valid), 64'd0);

        for (int kc = 0; kc < 3; kc++) begin
            for (int r = 0; r < 2; r++) begin
                run_block(2'(kc), r[0], 0, 1'b0, 1'b0,
                          r == 0 ? "R2 R3 R4 R7 R8" : "R3 R4 R7 R8");
                run_block(2'(kc), r[0], 0, 1'b1, 1'b0, "R5");
            end
        end
        run_block(2'd2, 1'b1, 1, 1'b0, 1'b0, "R4 R6 zeros");
        run_block(2'd0, 1'b0, 2, 1'b0, 1'b0, "R4 R6 ones");
        run_block(2'd3, 1'b0, 0, 1'b0, 1'b0, "R1 code 3");
        run_block(2'd1, 1'b0, 0, 1'b0, 1'b1, "R10 mid-block change");
        run_block(2'd2, 1'b1, 0, 1'b1, 1'b1, "R10 R5 change with flip");
        run_block(2'd1, 1'b1, 2, 1'b0, 1'b0, "R4 R8 ones");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule